// File: doc/BRIEF.md
# Variable-Page-Size Associative Translation Buffer

This block holds a table of 64 address translations and compares a virtual address with all of them at once. Each entry keeps a virtual page number, an 8-bit address-space identifier, a physical page number and nine flag bits. Two of the flag bits choose the entry's own page size: 1 KB, 4 KB, 64 KB or 1 MB. A lookup reports a single hit with its index and the translated physical address, a miss, or a multi-hit. The result is registered and appears one cycle after the request.

Software-style maintenance uses a second port. It writes or reads one entry by index, either the tag word or the data word. It can also perform an associative tag write. That write searches for the entry that translates the written page under the current identifier, and it changes only that entry's valid and dirty bits. A replacement counter steps on every lookup. It wraps at a programmable boundary or at the table size. A global invalidate clears every valid bit in one cycle.

Top module: `vtlb_unit`

## Requirements
- R1: While reset is asserted and after it is released, the lookup outputs, the read data, the associative multi-hit flag, the replacement counter and the boundary are all zero, and every entry is invalid, so the first lookup misses.
- R2: Flag bits {7,4} select the page size: 00 is 1 KB (mask 0xFFFFFC00), 01 is 4 KB (0xFFFFF000), 10 is 64 KB (0xFFFF0000) and 11 is 1 MB (0xFFF00000). On a hit, the physical address is (physical page AND mask) OR (virtual address AND NOT mask). The physical page is data bits [28:10] placed back at those positions.
- R3: An entry matches when all three of these hold: its valid flag (bit 8) is set; its share flag (bit 1) is set or its identifier equals the current identifier; and (tag XOR address) AND mask is zero.
- R4: With the skip-identifier input high, only the valid flag and the page compare decide a match.
- R5: When two or more entries match, the lookup reports multi-hit and not a hit.
- R6: One cycle after a lookup request, exactly one of hit, miss or multi-hit is high, along with done. Index and physical address are zero unless the result is a hit. With no request, done is low in the next cycle.
- R7: Every lookup advances the replacement counter by one. It returns to 0 instead when the incremented value equals the boundary or reaches 64.
- R8: A counter load or a boundary load takes effect at the next edge. A counter load overrides the increment of a lookup in the same cycle.
- R9: A direct tag write stores page = data[31:10], identifier = data[7:0], valid = data[8] and dirty flag (bit 2) = data[9]. A tag read returns {page, dirty at bit 9, valid at bit 8, identifier}.
- R10: A direct data write stores physical page = data[28:10] and all nine flags = data[8:0]. A data read returns {000, page, 0, flags} one cycle after the read request.
- R11: An associative tag write compares the write data as an address under the current identifier, with no skip. On exactly one match, it rewrites only that entry's valid flag (data[8]) and dirty flag (data[9]). With no match, nothing changes. With several matches, nothing changes and the multi-hit flag is high in the next cycle.
- R12: Global invalidate clears every valid flag in one cycle. A table write in the same cycle is dropped.
- R13: A lookup in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space identifier (lookup and associative write) |
| lk_skip_asid | input | 1 | Omit identifier/share test for this lookup |
| lk_done | output | 1 | Lookup result present |
| lk_hit | output | 1 | Single matching entry |
| lk_miss | output | 1 | No matching entry |
| lk_multi | output | 1 | Several matching entries |
| lk_index | output | 6 | Index of the hit entry |
| lk_paddr | output | 32 | Translated physical address |
| mm_wr | input | 1 | Table write strobe |
| mm_rd | input | 1 | Table read strobe |
| mm_sel_data | input | 1 | 1 selects the data word, 0 the tag word |
| mm_assoc | input | 1 | Tag write is associative |
| mm_addr | input | 6 | Entry index, address bits [13:8] |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data, one cycle after mm_rd |
| mm_amulti | output | 1 | Associative write found several matches |
| inv_all | input | 1 | Clear all valid flags |
| rc_ld | input | 1 | Load replacement counter |
| rc_ld_val | input | 6 | Counter load value |
| rb_ld | input | 1 | Load counter boundary |
| rb_ld_val | input | 6 | Boundary load value |
| rc_value | output | 6 | Replacement counter |
| rb_value | output | 6 | Counter boundary |

## Verification
Several functions can act on the same clock edge. A lookup can coincide with a data write to the entry it hits, with a counter load, or with a global invalidate. A table write can coincide with a global invalidate. The bench drives each pair together on one edge. It expects the lookup to return the physical address from before the write and the counter to take the loaded value. It expects the invalidate to drop the write, which a read-back of the entry and a later miss show. Random lookups aimed at stored pages, with random identifiers and skip settings, are compared against a table model kept in the bench.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int ADDR_W      = 32;
    localparam int PAGE_LSB    = 10;
    localparam int VPN_W       = ADDR_W - PAGE_LSB;
    localparam int PPN_MSB     = 28;
    localparam int PPN_W       = PPN_MSB - PAGE_LSB + 1;
    localparam int ASID_W      = 8;
    localparam int FLAG_W      = 9;
    localparam int TLB_IDX_LSB = 8;

    // flag bit positions
    localparam int FB_VALID = 8;
    localparam int FB_SZ_HI = 7;
    localparam int FB_SZ_LO = 4;
    localparam int FB_DIRTY = 2;
    localparam int FB_SHARE = 1;
    // dirty position inside a tag word
    localparam int WB_DIRTY = 9;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ASID_W-1:0] asid_t;
    typedef logic [FLAG_W-1:0] flags_t;

    typedef enum logic [1:0] {
        PG_1K  = 2'b00,
        PG_4K  = 2'b01,
        PG_64K = 2'b10,
        PG_1M  = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_MULTI = 2'd3
    } lk_status_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        asid_t            asid;
        logic [PPN_W-1:0] ppn;
        flags_t           flags;
    } tlb_entry_t;

    function automatic pg_size_e size_of(input flags_t fl);
        return pg_size_e'({fl[FB_SZ_HI], fl[FB_SZ_LO]});
    endfunction

    function automatic addr_t mask_of(input flags_t fl);
        addr_t m;
        case (size_of(fl))
            PG_1K:   m = 32'hFFFF_FC00;
            PG_4K:   m = 32'hFFFF_F000;
            PG_64K:  m = 32'hFFFF_0000;
            default: m = 32'hFFF0_0000;
        endcase
        return m;
    endfunction

    function automatic logic entry_hits(input tlb_entry_t e, input addr_t va,
                                        input asid_t asid, input logic skip);
        addr_t vbase;
        logic  id_ok;
        vbase = {e.vpn, {PAGE_LSB{1'b0}}};
        id_ok = skip | e.flags[FB_SHARE] | (e.asid == asid);
        return e.flags[FB_VALID] & id_ok & (((vbase ^ va) & mask_of(e.flags)) == '0);
    endfunction

    function automatic addr_t phys_of(input tlb_entry_t e, input addr_t va);
        addr_t pbase;
        addr_t m;
        pbase = {{(ADDR_W-PPN_MSB-1){1'b0}}, e.ppn, {PAGE_LSB{1'b0}}};
        m     = mask_of(e.flags);
        return (pbase & m) | (va & ~m);
    endfunction

    function automatic addr_t tag_word(input tlb_entry_t e);
        return {e.vpn, e.flags[FB_DIRTY], e.flags[FB_VALID], e.asid};
    endfunction

    function automatic addr_t data_word(input tlb_entry_t e);
        return {{(ADDR_W-PPN_MSB-1){1'b0}}, e.ppn, 1'b0, e.flags};
    endfunction

endpackage

// File: rtl/vtlb_match_enc.sv
module vtlb_match_enc #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic             many,
    output logic [IDX_W-1:0] idx
);

    assign any  = |vec;
    // clearing the lowest set bit leaves something only if two or more were set
    assign many = |(vec & (vec - N'(1)));

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vtlb_repl_ctr.sv
module vtlb_repl_ctr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CW = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             cnt_ld,
    input  logic [IDX_W-1:0] cnt_val,
    input  logic             bnd_ld,
    input  logic [IDX_W-1:0] bnd_val,
    output logic [IDX_W-1:0] cnt,
    output logic [IDX_W-1:0] bnd
);

    logic [CW-1:0] inc;
    logic          wrap;

    assign inc  = {1'b0, cnt} + CW'(1);
    assign wrap = (inc == {1'b0, bnd}) || (inc == CW'(ENTRIES));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bnd <= '0;
        end else begin
            if (cnt_ld) begin
                cnt <= cnt_val;
            end else if (step) begin
                cnt <= wrap ? '0 : inc[IDX_W-1:0];
            end
            if (bnd_ld) begin
                bnd <= bnd_val;
            end
        end
    end

endmodule

// File: rtl/vtlb_entry_array.sv
module vtlb_entry_array
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_all,
    input  logic             tag_we,
    input  logic             data_we,
    input  logic             flag_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  addr_t            wdata,
    input  addr_t            lk_va,
    input  asid_t            lk_asid,
    input  logic             lk_skip,
    input  asid_t            as_asid,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] as_match,
    output tlb_entry_t       rd_ent,
    output tlb_entry_t       hit_ent
);

    tlb_entry_t ents [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_entry_t ent_q;
        logic       sel;

        assign sel = (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (inv_all) begin
                ent_q.flags[FB_VALID] <= 1'b0;
            end else if (sel && tag_we) begin
                ent_q.vpn             <= wdata[ADDR_W-1:PAGE_LSB];
                ent_q.asid            <= wdata[ASID_W-1:0];
                ent_q.flags[FB_VALID] <= wdata[FB_VALID];
                ent_q.flags[FB_DIRTY] <= wdata[WB_DIRTY];
            end else if (sel && data_we) begin
                ent_q.ppn   <= wdata[PPN_MSB:PAGE_LSB];
                ent_q.flags <= wdata[FLAG_W-1:0];
            end else if (sel && flag_we) begin
                ent_q.flags[FB_VALID] <= wdata[FB_VALID];
                ent_q.flags[FB_DIRTY] <= wdata[WB_DIRTY];
            end
        end

        assign ents[g]     = ent_q;
        assign lk_match[g] = entry_hits(ent_q, lk_va, lk_asid, lk_skip);
        assign as_match[g] = entry_hits(ent_q, wdata, as_asid, 1'b0);
    end

    assign rd_ent  = ents[rd_idx];
    assign hit_ent = ents[hit_idx];

endmodule

// File: rtl/vtlb_unit.sv
module vtlb_unit
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   lk_valid,
    input  logic [ADDR_W-1:0]                      lk_vaddr,
    input  logic [ASID_W-1:0]                      cur_asid,
    input  logic                                   lk_skip_asid,
    output logic                                   lk_done,
    output logic                                   lk_hit,
    output logic                                   lk_miss,
    output logic                                   lk_multi,
    output logic [IDX_W-1:0]                       lk_index,
    output logic [ADDR_W-1:0]                      lk_paddr,
    input  logic                                   mm_wr,
    input  logic                                   mm_rd,
    input  logic                                   mm_sel_data,
    input  logic                                   mm_assoc,
    input  logic [TLB_IDX_LSB+IDX_W-1:TLB_IDX_LSB] mm_addr,
    input  logic [ADDR_W-1:0]                      mm_wdata,
    output logic [ADDR_W-1:0]                      mm_rdata,
    output logic                                   mm_amulti,
    input  logic                                   inv_all,
    input  logic                                   rc_ld,
    input  logic [IDX_W-1:0]                       rc_ld_val,
    input  logic                                   rb_ld,
    input  logic [IDX_W-1:0]                       rb_ld_val,
    output logic [IDX_W-1:0]                       rc_value,
    output logic [IDX_W-1:0]                       rb_value
);

    logic [IDX_W-1:0]   mm_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               assoc_req;
    logic               tag_we;
    logic               data_we;
    logic               flag_we;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] as_match;
    logic               lk_any;
    logic               lk_many;
    logic [IDX_W-1:0]   lk_sel;
    logic               as_any;
    logic               as_many;
    logic [IDX_W-1:0]   as_sel;
    tlb_entry_t         rd_ent;
    tlb_entry_t         hit_ent;

    lk_status_e         st_d;
    lk_status_e         st_q;
    logic [IDX_W-1:0]   idx_q;
    addr_t              pa_q;

    assign mm_idx    = mm_addr;
    assign assoc_req = mm_wr & ~mm_sel_data & mm_assoc;
    assign tag_we    = mm_wr & ~mm_sel_data & ~mm_assoc;
    assign data_we   = mm_wr & mm_sel_data;
    assign flag_we   = assoc_req & as_any & ~as_many;
    // an associative update is steered to the single entry that matched
    assign wr_idx    = assoc_req ? as_sel : mm_idx;

    vtlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk      (clk),
        .rst      (rst),
        .inv_all  (inv_all),
        .tag_we   (tag_we),
        .data_we  (data_we),
        .flag_we  (flag_we),
        .wr_idx   (wr_idx),
        .wdata    (mm_wdata),
        .lk_va    (lk_vaddr),
        .lk_asid  (cur_asid),
        .lk_skip  (lk_skip_asid),
        .as_asid  (cur_asid),
        .rd_idx   (mm_idx),
        .hit_idx  (lk_sel),
        .lk_match (lk_match),
        .as_match (as_match),
        .rd_ent   (rd_ent),
        .hit_ent  (hit_ent)
    );

    vtlb_match_enc #(.N(ENTRIES)) u_lk_enc (
        .vec  (lk_match),
        .any  (lk_any),
        .many (lk_many),
        .idx  (lk_sel)
    );

    vtlb_match_enc #(.N(ENTRIES)) u_as_enc (
        .vec  (as_match),
        .any  (as_any),
        .many (as_many),
        .idx  (as_sel)
    );

    vtlb_repl_ctr #(.ENTRIES(ENTRIES)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .step    (lk_valid),
        .cnt_ld  (rc_ld),
        .cnt_val (rc_ld_val),
        .bnd_ld  (rb_ld),
        .bnd_val (rb_ld_val),
        .cnt     (rc_value),
        .bnd     (rb_value)
    );

    always_comb begin
        if (!lk_valid) begin
            st_d = RES_NONE;
        end else if (!lk_any) begin
            st_d = RES_MISS;
        end else if (lk_many) begin
            st_d = RES_MULTI;
        end else begin
            st_d = RES_HIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= RES_NONE;
            idx_q     <= '0;
            pa_q      <= '0;
            mm_rdata  <= '0;
            mm_amulti <= 1'b0;
        end else begin
            st_q      <= st_d;
            idx_q     <= (st_d == RES_HIT) ? lk_sel : '0;
            pa_q      <= (st_d == RES_HIT) ? phys_of(hit_ent, lk_vaddr) : '0;
            mm_amulti <= assoc_req & as_many;
            if (mm_rd) begin
                mm_rdata <= mm_sel_data ? data_word(rd_ent) : tag_word(rd_ent);
            end
        end
    end

    assign lk_done  = (st_q != RES_NONE);
    assign lk_hit   = (st_q == RES_HIT);
    assign lk_miss  = (st_q == RES_MISS);
    assign lk_multi = (st_q == RES_MULTI);
    assign lk_index = idx_q;
    assign lk_paddr = pa_q;

endmodule

// File: rtl/vtlb_unit_chk.sv
module vtlb_unit_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_done,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_multi,
    input logic [IDX_W-1:0] lk_index,
    input logic [31:0]      lk_paddr,
    input logic             mm_wr,
    input logic             mm_sel_data,
    input logic             mm_assoc,
    input logic             mm_amulti,
    input logic             inv_all,
    input logic             rc_ld,
    input logic [IDX_W-1:0] rc_ld_val,
    input logic             rb_ld,
    input logic [IDX_W-1:0] rc_value,
    input logic [IDX_W-1:0] rb_value
);

    // R6
    one_status_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({lk_hit, lk_miss, lk_multi}) == int'(lk_done));

    // R6
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);

    // R6
    idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    // R6
    miss_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_miss || lk_multi) |-> (lk_paddr == '0 && lk_index == '0));

    // R7
    ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!lk_valid && !rc_ld) |=> $stable(rc_value));

    // R7
    ctr_avoid_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !rc_ld && !rb_ld && rb_value != '0) |=> (rc_value != rb_value));

    // R8
    ctr_load_chk: assert property (@(posedge clk) disable iff (rst)
        rc_ld |=> (rc_value == $past(rc_ld_val)));

    // R12
    inv_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all ##1 lk_valid |=> lk_miss);

    // R11
    amulti_source_chk: assert property (@(posedge clk) disable iff (rst)
        mm_amulti |-> $past(mm_wr && mm_assoc && !mm_sel_data));

endmodule

bind vtlb_unit vtlb_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_done     (lk_done),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_multi    (lk_multi),
    .lk_index    (lk_index),
    .lk_paddr    (lk_paddr),
    .mm_wr       (mm_wr),
    .mm_sel_data (mm_sel_data),
    .mm_assoc    (mm_assoc),
    .mm_amulti   (mm_amulti),
    .inv_all     (inv_all),
    .rc_ld       (rc_ld),
    .rc_ld_val   (rc_ld_val),
    .rb_ld       (rb_ld),
    .rc_value    (rc_value),
    .rb_value    (rb_value)
);

// File: tb/vtlb_unit_tb_top.sv
`timescale 1ns/1ps
module vtlb_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  cur_asid = '0;
    logic        lk_skip_asid = 1'b0;
    logic        lk_done, lk_hit, lk_miss, lk_multi;
    logic [5:0]  lk_index;
    logic [31:0] lk_paddr;
    logic        mm_wr = 1'b0;
    logic        mm_rd = 1'b0;
    logic        mm_sel_data = 1'b0;
    logic        mm_assoc = 1'b0;
    logic [13:8] mm_addr = '0;
    logic [31:0] mm_wdata = '0;
    logic [31:0] mm_rdata;
    logic        mm_amulti;
    logic        inv_all = 1'b0;
    logic        rc_ld = 1'b0;
    logic [5:0]  rc_ld_val = '0;
    logic        rb_ld = 1'b0;
    logic [5:0]  rb_ld_val = '0;
    logic [5:0]  rc_value, rb_value;

    always #10 clk = ~clk;

    vtlb_unit dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .cur_asid(cur_asid),
        .lk_skip_asid(lk_skip_asid),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
        .lk_index(lk_index), .lk_paddr(lk_paddr),
        .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_sel_data(mm_sel_data), .mm_assoc(mm_assoc),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_amulti(mm_amulti),
        .inv_all(inv_all),
        .rc_ld(rc_ld), .rc_ld_val(rc_ld_val), .rb_ld(rb_ld), .rb_ld_val(rb_ld_val),
        .rc_value(rc_value), .rb_value(rb_value)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference table
    logic [21:0] m_vpn  [64];
    logic [7:0]  m_asid [64];
    logic [18:0] m_ppn  [64];
    logic [8:0]  m_fl   [64];
    int          m_cnt = 0;
    int          m_bnd = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_mask(input logic [8:0] fl);
        case ({fl[7], fl[4]})
            2'b00:   return 32'hFFFF_FC00;
            2'b01:   return 32'hFFFF_F000;
            2'b10:   return 32'hFFFF_0000;
            default: return 32'hFFF0_0000;
        endcase
    endfunction

    task automatic model_lookup(input logic [31:0] va, input logic [7:0] asid,
                                input logic skip, output int n, output int ix,
                                output logic [31:0] pa);
        n = 0; ix = 0; pa = '0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] m;
            m = f_mask(m_fl[i]);
            if (m_fl[i][8] && (skip || m_fl[i][1] || m_asid[i] == asid) &&
                ((({m_vpn[i], 10'b0} ^ va) & m) == 32'h0)) begin
                n++;
                ix = i;
                pa = ({3'b000, m_ppn[i], 10'b0} & m) | (va & ~m);
            end
        end
    endtask

    task automatic ctr_step();
        m_cnt = m_cnt + 1;
        if (m_cnt == m_bnd || m_cnt == 64) m_cnt = 0;
    endtask

    task automatic do_lookup(input string req, input logic [31:0] va,
                             input logic [7:0] asid, input logic skip,
                             input bit with_wr = 1'b0, input int wi = 0,
                             input logic [31:0] wd = '0,
                             input bit with_ld = 1'b0, input int lv = 0);
        int n, ix;
        logic [31:0] pa;
        model_lookup(va, asid, skip, n, ix, pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; cur_asid = asid; lk_skip_asid = skip;
        if (with_wr) begin
            mm_wr = 1'b1; mm_sel_data = 1'b1; mm_assoc = 1'b0;
            mm_addr = 6'(wi); mm_wdata = wd;
        end
        if (with_ld) begin
            rc_ld = 1'b1; rc_ld_val = 6'(lv);
        end
        @(negedge clk);
        lk_valid = 1'b0; mm_wr = 1'b0; rc_ld = 1'b0;
        if (with_wr) begin
            m_ppn[wi] = wd[28:10]; m_fl[wi] = wd[8:0];
        end
        if (with_ld) m_cnt = lv;
        else ctr_step();
        chk(req, "done",  32'(lk_done), 32'd1);
        chk(req, "hit",   32'(lk_hit),   32'(n == 1));
        chk(req, "miss",  32'(lk_miss),  32'(n == 0));
        chk(req, "multi", 32'(lk_multi), 32'(n > 1));
        chk(req, "index", 32'(lk_index), (n == 1) ? 32'(ix) : 32'd0);
        chk(req, "paddr", lk_paddr, (n == 1) ? pa : 32'd0);
        chk(req, "counter", 32'(rc_value), 32'(m_cnt));
    endtask

    task automatic wr_tag(input int idx, input logic [31:0] d, input bit with_inv = 1'b0);
        @(negedge clk);
        mm_wr = 1'b1; mm_sel_data = 1'b0; mm_assoc = 1'b0; mm_addr = 6'(idx); mm_wdata = d;
        inv_all = with_inv;
        @(negedge clk);
        mm_wr = 1'b0; inv_all = 1'b0;
        if (with_inv) begin
            for (int i = 0; i < 64; i++) m_fl[i][8] = 1'b0;
        end else begin
            m_vpn[idx] = d[31:10]; m_asid[idx] = d[7:0];
            m_fl[idx][8] = d[8]; m_fl[idx][2] = d[9];
        end
    endtask

    task automatic wr_dat(input int idx, input logic [31:0] d);
        @(negedge clk);
        mm_wr = 1'b1; mm_sel_data = 1'b1; mm_assoc = 1'b0; mm_addr = 6'(idx); mm_wdata = d;
        @(negedge clk);
        mm_wr = 1'b0;
        m_ppn[idx] = d[28:10]; m_fl[idx] = d[8:0];
    endtask

    task automatic wr_assoc(input string req, input logic [31:0] d, input logic [7:0] asid);
        int n, ix;
        logic [31:0] pa;
        model_lookup(d, asid, 1'b0, n, ix, pa);
        @(negedge clk);
        mm_wr = 1'b1; mm_sel_data = 1'b0; mm_assoc = 1'b1; mm_wdata = d; cur_asid = asid;
        @(negedge clk);
        mm_wr = 1'b0; mm_assoc = 1'b0;
        if (n == 1) begin
            m_fl[ix][8] = d[8]; m_fl[ix][2] = d[9];
        end
        chk(req, "assoc multi flag", 32'(mm_amulti), 32'(n > 1));
    endtask

    task automatic rd_chk(input string req, input bit sel, input int idx);
        logic [31:0] e;
        @(negedge clk);
        mm_rd = 1'b1; mm_sel_data = sel; mm_addr = 6'(idx);
        @(negedge clk);
        mm_rd = 1'b0;
        e = sel ? {3'b000, m_ppn[idx], 1'b0, m_fl[idx]}
                : {m_vpn[idx], m_fl[idx][2], m_fl[idx][8], m_asid[idx]};
        chk(req, sel ? "data read" : "tag read", mm_rdata, e);
    endtask

    task automatic cfg(input string req, input bit ldc, input int cv, input bit ldb, input int bv);
        @(negedge clk);
        rc_ld = ldc; rc_ld_val = 6'(cv); rb_ld = ldb; rb_ld_val = 6'(bv);
        @(negedge clk);
        rc_ld = 1'b0; rb_ld = 1'b0;
        if (ldc) m_cnt = cv;
        if (ldb) m_bnd = bv;
        chk(req, "counter", 32'(rc_value), 32'(m_cnt));
        chk(req, "bound", 32'(rb_value), 32'(m_bnd));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd9127);
        for (int i = 0; i < 64; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0; m_fl[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 values held during reset
        chk("R1", "done in reset", 32'(lk_done), 32'd0);
        chk("R1", "paddr in reset", lk_paddr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "hit", 32'(lk_hit), 32'd0);
        chk("R1", "rdata", mm_rdata, 32'd0);
        chk("R1", "amulti", 32'(mm_amulti), 32'd0);
        chk("R1", "counter", 32'(rc_value), 32'd0);
        chk("R1", "bound", 32'(rb_value), 32'd0);
        do_lookup("R1", 32'h0000_0000, 8'h00, 1'b1);
        rd_chk("R1", 1'b0, 17);

        // R9 / R10 field placement
        wr_tag(5, 32'h0012_333C);
        rd_chk("R9", 1'b0, 5);
        chk("R9", "tag word literal", mm_rdata, 32'h0012_333C);
        wr_dat(5, 32'h0ABC_D114);
        rd_chk("R10", 1'b1, 5);
        chk("R10", "data word literal", mm_rdata, 32'h0ABC_D114);
        wr_dat(7, 32'hFFFF_FFFF);
        rd_chk("R10", 1'b1, 7);
        chk("R10", "masked data word", mm_rdata, 32'h1FFF_FDFF);

        // R2 page sizes
        do_lookup("R2", 32'h0012_3ABC, 8'h3C, 1'b0);
        chk("R2", "4K paddr literal", lk_paddr, 32'h0ABC_DABC);
        wr_tag(9, 32'h8030_0107);
        wr_dat(9, 32'h1F00_0190);
        do_lookup("R2", 32'h803F_FFF0, 8'h07, 1'b0);
        chk("R2", "1M paddr literal", lk_paddr, 32'h1F0F_FFF0);
        wr_tag(10, 32'h4001_0107);
        wr_dat(10, 32'h0200_0180);
        do_lookup("R2", 32'h4001_ABCD, 8'h07, 1'b0);
        chk("R2", "64K paddr literal", lk_paddr, 32'h0200_ABCD);
        wr_tag(11, 32'h6000_0507);
        wr_dat(11, 32'h0100_0900);
        do_lookup("R2", 32'h6000_07FF, 8'h07, 1'b0);
        chk("R2", "1K paddr literal", lk_paddr, 32'h0100_0BFF);

        // R3 identifier and share
        do_lookup("R3", 32'h0012_3004, 8'h3D, 1'b0);
        wr_dat(5, 32'h0ABC_D116);
        do_lookup("R3", 32'h0012_3004, 8'h3D, 1'b0);

        // R4 skip identifier
        do_lookup("R4", 32'h8031_0000, 8'h55, 1'b1);
        do_lookup("R4", 32'h8031_0000, 8'h55, 1'b0);

        // R5 overlap gives multi-hit
        wr_tag(12, 32'h8030_0107);
        wr_dat(12, 32'h0300_0100);
        do_lookup("R5", 32'h8030_0010, 8'h07, 1'b0);

        // R11 associative writes
        wr_assoc("R11", 32'h8030_0000, 8'h07);
        rd_chk("R11", 1'b1, 12);
        rd_chk("R11", 1'b1, 9);
        wr_assoc("R11", 32'h0012_3200, 8'h11);
        rd_chk("R11", 1'b0, 5);
        chk("R11", "tag after assoc literal", mm_rdata, 32'h0012_323C);
        rd_chk("R11", 1'b1, 5);
        wr_assoc("R11", 32'h7000_0100, 8'h00);
        rd_chk("R11", 1'b0, 11);

        // R7 counter wrap at boundary and at 64
        cfg("R8", 1'b1, 3, 1'b1, 5);
        do_lookup("R7", 32'h0, 8'h0, 1'b0);
        do_lookup("R7", 32'h0, 8'h0, 1'b0);
        chk("R7", "wrap at bound", 32'(rc_value), 32'd0);
        cfg("R8", 1'b1, 62, 1'b1, 0);
        do_lookup("R7", 32'h0, 8'h0, 1'b0);
        do_lookup("R7", 32'h0, 8'h0, 1'b0);
        chk("R7", "wrap at 64", 32'(rc_value), 32'd0);

        // R8 load beats increment
        do_lookup("R8", 32'h4001_0000, 8'h07, 1'b0, 1'b0, 0, 32'h0, 1'b1, 20);

        // R13 lookup concurrent with a data write to the hit entry
        do_lookup("R13", 32'h4001_1234, 8'h07, 1'b0, 1'b1, 10, 32'h0555_0180);
        do_lookup("R13", 32'h4001_1234, 8'h07, 1'b0);

        // R12 invalidate with a concurrent write
        wr_tag(20, 32'hC000_0107, 1'b1);
        rd_chk("R12", 1'b0, 20);
        rd_chk("R12", 1'b1, 10);
        do_lookup("R12", 32'h4001_1234, 8'h07, 1'b0);

        // constrained random mix
        for (int it = 0; it < 700; it++) begin
            int op;
            int idx;
            op  = int'($urandom % 7);
            idx = int'($urandom % 64);
            case (op)
                0: wr_tag(idx, {$urandom} & 32'hFFFF_FF03 |
                               (($urandom % 4 != 0) ? 32'h100 : 32'h0) |
                               (32'($urandom % 2) << 9));
                1: wr_dat(idx, ({$urandom} & 32'h1FFF_FEFF) |
                               (($urandom % 5 != 0) ? 32'h100 : 32'h0));
                2, 3: begin
                    logic [31:0] va;
                    logic [7:0]  as;
                    va = {m_vpn[idx], 10'b0} ^ ({$urandom} & ~f_mask(m_fl[idx]));
                    as = ($urandom % 4 == 0) ? 8'($urandom % 4) : m_asid[idx];
                    do_lookup("R3", va, as, ($urandom % 4) == 0);
                end
                4: do_lookup("R4", {$urandom}, 8'($urandom % 4), 1'b1);
                5: rd_chk("R9", ($urandom % 2) == 1, idx);
                default: begin
                    if ($urandom % 3 == 0) cfg("R8", 1'b0, 0, 1'b1, int'($urandom % 64));
                    else wr_assoc("R11", {m_vpn[idx], 10'b0} | (32'($urandom % 4) << 8),
                                  m_asid[idx]);
                end
            endcase
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule